// File: doc/BRIEF.md
# Per-Channel Programmable Edge Delay

One channel of a quad timing-deskew element, modelled digitally on a sample clock. A source selector picks either a signal shared by all channels or this channel's own input. The picked signal enters a history line with one bit per tick. The output is built from two positions in that history. The rising-edge position comes from a coarse code, a fine code that can be bypassed and a fixed base delay. The falling-edge position is the rising position moved by a signed offset, and that offset can also be bypassed. Four instances with a common shared input form the quad element.

Coarse and fine codes move both edges by the same amount, so pulse width is kept. The falling-edge offset widens or narrows pulses. A pulse narrowed to zero ticks disappears. A low gap that a widened pulse would cross is filled, so edges are never reordered. The control codes are expected to be quasi-static. They come from a separate register interface and are only changed while the input is idle.

Top module: `chan_edge_delay`

## Requirements
- R1: When `sel_fanout` is 1 the channel delays `fan_in` and ignores `own_in`. When it is 0 the channel delays `own_in` and ignores `fan_in`.
- R2: A synchronous low on `rst_n` drives `dly_out` to 0 on the next edge and clears the history, so an input held high during reset produces no output pulse after release.
- R3: The rising-edge delay is Dr = 64 + 4*`coarse_code` + (`fine_en` ? `fine_code` : 0) ticks. An input first sampled high at edge k shows as `dly_out` high after edge k+Dr+1.
- R4: With `fine_en` = 0 the value of `fine_code` has no effect on timing.
- R5: With `fall_en` = 0 every output pulse, and every low gap, has the same length in ticks as at the input, for any coarse and fine code.
- R6: With `fall_en` = 1 the falling edge is delayed by Df = Dr + `fall_code` - 64 ticks (code 0 gives -64, 64 gives 0, 127 gives +63). The rising edge still uses Dr, and an isolated pulse of w ticks becomes w + `fall_code` - 64 ticks wide.
- R7: With `fall_en` = 0 the value of `fall_code` has no effect on timing.
- R8: With a negative offset, an input pulse of w <= 64 - `fall_code` ticks produces no output pulse at all.
- R9: With a positive offset, an input low gap of g <= `fall_code` - 64 ticks between two pulses is filled, giving one merged output pulse. A larger gap keeps the two pulses apart.
- R10: The largest setting (coarse 63, fine enabled at 63, fall enabled at 127) gives Dr = 379 and Df = 442 ticks without loss of the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one period is one tick |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_fanout | input | 1 | 1 picks the shared input, 0 the channel's own input |
| fan_in | input | 1 | Shared fanout timing signal |
| own_in | input | 1 | This channel's pass-through timing signal |
| coarse_code | input | 6 | Coarse delay code, 4 ticks per step |
| fine_en | input | 1 | Enables the fine stage |
| fine_code | input | 6 | Fine delay code, 1 tick per step |
| fall_en | input | 1 | Enables the falling-edge offset |
| fall_code | input | 7 | Falling-edge offset code, offset = code - 64 ticks |
| dly_out | output | 1 | Delayed, edge-shaped timing signal |

## Verification
Errors in the delay arithmetic show up as a shift of the rising edge, or as a change of output pulse width. Each appears on the first pulse after the codes are set, between 66 and 444 ticks after the input edge. A wrong window in the edge shaper shows up as a pulse that should merge but splits, or a pulse that should be suppressed but leaks through, on the same pulse. A history that is not cleared by reset shows up as a spurious pulse within about 450 ticks after reset is released. The sweeps measure the position of the first rising edge, the total high time and the number of output pulses.

// File: rtl/chan_edge_delay_pkg.sv
// Package: shared types and sizing helpers for the edge delay channel.
// Assumes widths are small enough that the history depth stays modest.
package chan_edge_delay_pkg;

    // How the output window combines history bits.
    typedef enum logic {
        SHAPE_STRETCH = 1'b0,   // falling edge at or after rising: OR over window
        SHAPE_TRIM    = 1'b1    // falling edge before rising: AND over window
    } shape_e;

    // Largest rising-edge delay in ticks for the given code widths and step sizes.
    function automatic int max_rise_ticks(input int cw, input int fw, input int aw,
                                          input int c_ticks, input int f_ticks);
        return (1 << (aw - 1)) + ((1 << cw) - 1) * c_ticks + ((1 << fw) - 1) * f_ticks;
    endfunction

endpackage

// File: rtl/chan_src_mux.sv
// Module: chan_src_mux
// Picks the timing source for one channel: the shared fanout input or the
// channel's own input. Purely combinational; the history line registers it.
module chan_src_mux (
    input  logic sel_fanout,
    input  logic fan_in,
    input  logic own_in,
    output logic src
);

    // Source choice: fanout when selected, pass-through otherwise.
    always_comb begin
        src = sel_fanout ? fan_in : own_in;
    end

endmodule

// File: rtl/chan_delay_calc.sv
// Module: chan_delay_calc
// Turns the control codes into history indices for the rising edge and the
// falling edge, plus the window bounds and the combining mode.
// Assumes the base delay equals half the falling-code range, so the falling
// index never goes below zero.
module chan_delay_calc
    import chan_edge_delay_pkg::*;
#(
    parameter int COARSE_W     = 6,
    parameter int FINE_W       = 6,
    parameter int FALL_W       = 7,
    parameter int COARSE_TICKS = 4,
    parameter int FINE_TICKS   = 1,
    parameter int IDX_W        = 9
) (
    input  logic [COARSE_W-1:0] coarse_code,
    input  logic                fine_en,
    input  logic [FINE_W-1:0]   fine_code,
    input  logic                fall_en,
    input  logic [FALL_W-1:0]   fall_code,
    output logic [IDX_W-1:0]    rise_idx,
    output logic [IDX_W-1:0]    fall_idx,
    output logic [IDX_W-1:0]    lo_idx,
    output logic [IDX_W-1:0]    hi_idx,
    output shape_e              mode
);

    localparam int BASE = 1 << (FALL_W - 1);

    logic [IDX_W-1:0] coarse_part;
    logic [IDX_W-1:0] fine_part;

    // Stage contributions: coarse always, fine only when enabled.
    always_comb begin
        coarse_part = IDX_W'(coarse_code) * IDX_W'(COARSE_TICKS);
        fine_part   = fine_en ? IDX_W'(fine_code) * IDX_W'(FINE_TICKS) : '0;
    end

    // Edge positions: rising sits on the base, falling is offset from it.
    always_comb begin
        rise_idx = IDX_W'(BASE) + coarse_part + fine_part;
        fall_idx = fall_en ? (coarse_part + fine_part + IDX_W'(fall_code)) : rise_idx;
    end

    // Window bounds and combining mode from the edge order.
    always_comb begin
        if (fall_idx >= rise_idx) begin
            mode   = SHAPE_STRETCH;
            lo_idx = rise_idx;
            hi_idx = fall_idx;
        end else begin
            mode   = SHAPE_TRIM;
            lo_idx = fall_idx;
            hi_idx = rise_idx;
        end
    end

endmodule

// File: rtl/chan_tap_line.sv
// Module: chan_tap_line
// One-bit-per-tick history of the chosen source. Bit k holds the source as
// sampled k edges earlier. Also exposes the bits at the two edge indices.
// Assumes both indices are below DEPTH.
module chan_tap_line #(
    parameter int DEPTH = 443,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src,
    input  logic [IDX_W-1:0] rise_idx,
    input  logic [IDX_W-1:0] fall_idx,
    output logic [DEPTH-1:0] hist,
    output logic             tap_rise,
    output logic             tap_fall
);

    // History shift: newest sample enters at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[DEPTH-2:0], src};
        end
    end

    // Single-bit taps at the rising and falling edge positions.
    always_comb begin
        tap_rise = hist[rise_idx];
        tap_fall = hist[fall_idx];
    end

endmodule

// File: rtl/chan_edge_shaper.sv
// Module: chan_edge_shaper
// Builds the output from the history window [lo_idx, hi_idx]. In stretch mode
// the output is high if any bit in the window is high. In trim mode it is high
// only if all bits in the window are high. The first widens pulses and fills
// short gaps; the second narrows pulses and drops ones that shrink to nothing.
module chan_edge_shaper
    import chan_edge_delay_pkg::*;
#(
    parameter int DEPTH = 443,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] hist,
    input  logic [IDX_W-1:0] lo_idx,
    input  logic [IDX_W-1:0] hi_idx,
    input  shape_e           mode,
    input  logic             tap_rise,
    input  logic             tap_fall,
    output logic             dly_out
);

    logic [DEPTH-1:0] win_mask;
    logic             any_high;
    logic             all_high;

    // Window mask: one bit per history position inside the bounds.
    for (genvar i = 0; i < DEPTH; i++) begin : g_mask
        assign win_mask[i] = (IDX_W'(i) >= lo_idx) && (IDX_W'(i) <= hi_idx);
    end

    // Window reductions for both combining modes.
    always_comb begin
        any_high = |(hist & win_mask);
        all_high = &(hist | ~win_mask);
    end

    // Output register: picks the reduction that matches the edge order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_out <= 1'b0;
        end else begin
            dly_out <= (mode == SHAPE_STRETCH) ? any_high : all_high;
        end
    end

    // R2: reset clears the output on the next edge.
    p_reset_clear_r2: assert property (@(posedge clk)
        !rst_n |=> !dly_out);

    // R6: with the falling edge late, a high falling tap keeps the output high.
    p_stretch_fall_tap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SHAPE_STRETCH && tap_fall) |=> dly_out);

    // R9: with the falling edge late, a high rising tap keeps the output high.
    p_stretch_rise_tap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SHAPE_STRETCH && tap_rise) |=> dly_out);

    // R8: in trim mode the output needs both taps high.
    p_trim_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SHAPE_TRIM && !(tap_rise && tap_fall)) |=> !dly_out);

    // R5: with coincident edges the output follows the single tap.
    p_aligned_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_idx == hi_idx) |=> (dly_out == $past(tap_rise)));

endmodule

// File: rtl/chan_edge_delay.sv
// Module: chan_edge_delay (top)
// One deskew channel. Source select, then a tick history, then an output that
// takes its rising edge from one history index and its falling edge from another.
// Assumes the control codes are changed only while the source is idle.
module chan_edge_delay
    import chan_edge_delay_pkg::*;
#(
    parameter int COARSE_W     = 6,
    parameter int FINE_W       = 6,
    parameter int FALL_W       = 7,
    parameter int COARSE_TICKS = 4,
    parameter int FINE_TICKS   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_fanout,
    input  logic                fan_in,
    input  logic                own_in,
    input  logic [COARSE_W-1:0] coarse_code,
    input  logic                fine_en,
    input  logic [FINE_W-1:0]   fine_code,
    input  logic                fall_en,
    input  logic [FALL_W-1:0]   fall_code,
    output logic                dly_out
);

    localparam int MAX_RISE = max_rise_ticks(COARSE_W, FINE_W, FALL_W, COARSE_TICKS, FINE_TICKS);
    localparam int DEPTH    = MAX_RISE + (1 << (FALL_W - 1));
    localparam int IDX_W    = $clog2(DEPTH);

    logic             src;
    logic [IDX_W-1:0] rise_idx;
    logic [IDX_W-1:0] fall_idx;
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;
    shape_e           mode;
    logic [DEPTH-1:0] hist;
    logic             tap_rise;
    logic             tap_fall;

    chan_src_mux u_mux (
        .sel_fanout (sel_fanout),
        .fan_in     (fan_in),
        .own_in     (own_in),
        .src        (src)
    );

    chan_delay_calc #(
        .COARSE_W     (COARSE_W),
        .FINE_W       (FINE_W),
        .FALL_W       (FALL_W),
        .COARSE_TICKS (COARSE_TICKS),
        .FINE_TICKS   (FINE_TICKS),
        .IDX_W        (IDX_W)
    ) u_calc (
        .coarse_code (coarse_code),
        .fine_en     (fine_en),
        .fine_code   (fine_code),
        .fall_en     (fall_en),
        .fall_code   (fall_code),
        .rise_idx    (rise_idx),
        .fall_idx    (fall_idx),
        .lo_idx      (lo_idx),
        .hi_idx      (hi_idx),
        .mode        (mode)
    );

    chan_tap_line #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .rise_idx (rise_idx),
        .fall_idx (fall_idx),
        .hist     (hist),
        .tap_rise (tap_rise),
        .tap_fall (tap_fall)
    );

    chan_edge_shaper #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .hist     (hist),
        .lo_idx   (lo_idx),
        .hi_idx   (hi_idx),
        .mode     (mode),
        .tap_rise (tap_rise),
        .tap_fall (tap_fall),
        .dly_out  (dly_out)
    );

    // R1: in fanout mode the newest history bit is the shared input.
    p_fanout_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fanout |=> (hist[0] == $past(fan_in)));

    // R1: in pass-through mode the newest history bit is the own input.
    p_own_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_fanout |=> (hist[0] == $past(own_in)));

endmodule

// File: tb/test_chan_edge_delay.sv
`timescale 1ns/1ps
// Bench: sweeps codes and pulse shapes and measures the first rise, total high
// time and pulse count at the output against arithmetic expectations.
module test_chan_edge_delay;

    localparam int OBS_EXTRA = 460;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_fanout = 1'b1;
    logic       fan_in = 1'b0;
    logic       own_in = 1'b0;
    logic [5:0] coarse_code = '0;
    logic       fine_en = 1'b0;
    logic [5:0] fine_code = '0;
    logic       fall_en = 1'b0;
    logic [6:0] fall_code = '0;
    logic       dly_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    chan_edge_delay i_chan_edge_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_fanout  (sel_fanout),
        .fan_in      (fan_in),
        .own_in      (own_in),
        .coarse_code (coarse_code),
        .fine_en     (fine_en),
        .fine_code   (fine_code),
        .fall_en     (fall_en),
        .fall_code   (fall_code),
        .dly_out     (dly_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drives a pulse pattern on one input from negedge 0 and observes the output.
    task automatic drive_obs(input bit on_fan, input int w1, input int gap, input int w2,
                             output int first_rise, output int highs, output int npulse);
        int  total;
        bit  prev;
        bit  v;
        total      = w1 + gap + w2;
        prev       = 1'b0;
        first_rise = -1;
        highs      = 0;
        npulse     = 0;
        for (int j = 0; j < total + OBS_EXTRA; j++) begin
            @(negedge clk);
            if (dly_out) highs++;
            if (dly_out && !prev) begin
                npulse++;
                if (first_rise < 0) first_rise = j;
            end
            prev = dly_out;
            v = (j < w1) || (w2 > 0 && j >= w1 + gap && j < total);
            if (on_fan) fan_in = v; else own_in = v;
        end
        fan_in = 1'b0;
        own_in = 1'b0;
    endtask

    function automatic int exp_rise(input int c, input bit fe, input int f);
        return 64 + 4 * c + (fe ? f : 0);
    endfunction

    // Single isolated pulse of w ticks on the selected source; checks shape.
    task automatic single(input string req, input int c, input bit fe, input int f,
                          input bit fa, input int fc, input int w);
        int dr, delta, r, h, n;
        coarse_code = 6'(c); fine_en = fe; fine_code = 6'(f);
        fall_en = fa; fall_code = 7'(fc);
        dr    = exp_rise(c, fe, f);
        delta = fa ? fc - 64 : 0;
        drive_obs(sel_fanout, w, 0, 0, r, h, n);
        if (w + delta <= 0) begin
            check(req, "pulse count (suppressed)", n, 0);
            check(req, "high ticks (suppressed)", h, 0);
        end else begin
            check(req, "pulse count", n, 1);
            check(req, "first rise index", r, dr + 2);
            check(req, "high ticks", h, w + delta);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int r, h, n;
        int coarse_set[6] = '{0, 1, 2, 5, 31, 63};
        int fine_set[4]   = '{0, 1, 17, 63};
        int fall_set[8]   = '{0, 1, 32, 63, 64, 65, 100, 127};

        // R2: output low during reset with the input high; no residue after.
        rst_n = 1'b0; sel_fanout = 1'b1; fan_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", "output in reset", int'(dly_out), 0);
        fan_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive_obs(1'b1, 0, 0, 0, r, h, n);
        check("R2", "high ticks after reset", h, 0);

        // R1: fanout mode follows fan_in and ignores own_in.
        sel_fanout = 1'b1;
        single("R1", 2, 1'b0, 0, 1'b0, 0, 4);
        drive_obs(1'b0, 4, 0, 0, r, h, n);
        check("R1", "own_in ignored in fanout", n, 0);
        // R1: pass-through mode follows own_in and ignores fan_in.
        sel_fanout = 1'b0;
        single("R1", 2, 1'b0, 0, 1'b0, 0, 4);
        drive_obs(1'b1, 4, 0, 0, r, h, n);
        check("R1", "fan_in ignored in pass-through", n, 0);
        sel_fanout = 1'b1;

        // R3 and R5: sweep coarse and fine, both fine modes, no fall offset.
        foreach (coarse_set[i]) begin
            foreach (fine_set[k]) begin
                single("R3", coarse_set[i], 1'b1, fine_set[k], 1'b0, 0, 3);
                // R4: fine code has no effect when the fine stage is off.
                single("R4", coarse_set[i], 1'b0, fine_set[k], 1'b0, 0, 3);
            end
        end

        // R5: two pulses with a one-tick gap keep their shape.
        coarse_code = 6'd7; fine_en = 1'b1; fine_code = 6'd9; fall_en = 1'b0; fall_code = 7'd0;
        drive_obs(1'b1, 3, 1, 3, r, h, n);
        check("R5", "pulse count gap 1", n, 2);
        check("R5", "high ticks gap 1", h, 6);
        check("R5", "first rise gap 1", r, exp_rise(7, 1'b1, 9) + 2);

        // R6: sweep the falling-edge code on a wide pulse.
        foreach (fall_set[i]) begin
            single("R6", 3, 1'b1, 9, 1'b1, fall_set[i], 70);
        end

        // R7: fall code ignored when the offset stage is off.
        single("R7", 3, 1'b1, 9, 1'b0, 0, 5);
        single("R7", 3, 1'b1, 9, 1'b0, 127, 5);

        // R8: trim boundary, shift of -4 and of -64.
        single("R8", 4, 1'b0, 0, 1'b1, 60, 4);
        single("R8", 4, 1'b0, 0, 1'b1, 60, 5);
        single("R8", 4, 1'b0, 0, 1'b1, 0, 64);
        single("R8", 4, 1'b0, 0, 1'b1, 0, 65);

        // R9: stretch of +4 merges a 4-tick gap, keeps a 5-tick gap.
        coarse_code = 6'd1; fine_en = 1'b0; fine_code = 6'd0; fall_en = 1'b1; fall_code = 7'd68;
        drive_obs(1'b1, 3, 4, 3, r, h, n);
        check("R9", "pulse count gap 4", n, 1);
        check("R9", "high ticks gap 4", h, 14);
        drive_obs(1'b1, 3, 5, 3, r, h, n);
        check("R9", "pulse count gap 5", n, 2);
        check("R9", "high ticks gap 5", h, 14);
        check("R9", "first rise gap 5", r, exp_rise(1, 1'b0, 0) + 2);

        // R10: full-scale setting.
        single("R10", 63, 1'b1, 63, 1'b1, 127, 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule